// File: doc/BRIEF.md
# Two-Domain Mailbox with Doorbells

This block is a register-mapped mailbox that links two processor domains, called side A and side B, running on one clock. Each side sees its own bank of ten 32-bit registers: four outbound data slots, four inbound data slots, a status word and a control word. A word written into outbound slot n on one side appears in inbound slot n on the other side. A pair of flags per slot tells the writer when the slot is free and tells the reader when a word is waiting.

Besides the data slots, each side can ring four doorbells toward its peer. A doorbell request raises a pending bit on the other side. That pending bit stays set until the peer software writes a one over it. Each side also passes three general flag bits across to the peer's status word. One interrupt line per side merges the pending, receive-full and transmit-empty conditions that the local control word has enabled.

Both buses are simple synchronous ports: a write strobe and a read strobe with a byte address, and read data that is valid in the same cycle as the address. A read of an inbound slot consumes the word at the clock edge that ends the read cycle.

Top module: `mbox_dual`

## Requirements
- R1: Byte offsets per side: outbound slot n at 4*n, inbound slot n at 0x10+4*n, status at 0x20, control at 0x24. Accesses whose address bits 1:0 are not zero have no effect and read 0. Reading an outbound slot returns the last word written to it.
- R2: After synchronous reset, each status word reads 0x00F00000 (all transmit-empty set), each control word reads 0, and both interrupt outputs are 0.
- R3: Writing outbound slot n clears the writer's transmit-empty bit n (status bit 23-n) and sets the peer's receive-full bit n (status bit 27-n). The peer's inbound slot n then returns the written word.
- R4: Reading inbound slot n returns the word and clears receive-full bit n at the end of the cycle, which sets the sender's transmit-empty bit n again. A read while receive-full is clear changes no flag.
- R5: Writing status with bit 31-n set clears pending doorbell n only. Other pending bits and all other status bits are unchanged.
- R6: Writing control with bit 19-n set rings doorbell n: the peer's pending bit n (status bit 31-n) sets. Control bit 19-n reads 1 until the peer clears that pending bit, and then reads 0 without any further write.
- R7: Control bits 31-n, 27-n and 23-n are the enables for pending n, receive-full n and transmit-empty n, and they read back as written. The side's interrupt is the OR over n of each enabled condition.
- R8: Control bits 2:0 written on one side appear as status bits 2:0 on the peer.
- R9: Writes to inbound slots have no effect. Writes to status bits other than the pending bits have no effect.
- R10: The two sides behave the same way: traffic from B to A follows R3 and R4 with the roles swapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational from address |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational from address |
| b_irq | output | 1 | Side B interrupt |

## Verification
The checks on slot flags assume both sides follow the slot protocol. A sender writes outbound slot n only while its transmit-empty bit n is set, and a receiver reads inbound slot n only while receive-full n is set, so the two sides never write and read the same slot in one cycle. The stimulus keeps to this rule. Each data word is written once into an empty slot and drained once. The only deliberate read of an empty slot comes after a drain, and nothing writes that slot at the same time. All accesses in the stimulus are word aligned except the one misaligned write used to check R1.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int MB_CH    = 4;
    localparam int MB_DW    = 32;
    localparam int MB_AW    = 6;
    localparam int MB_NFLAG = 3;
    localparam int MB_IW    = $clog2(MB_CH);

    // word indices (byte address >> 2)
    localparam logic [MB_AW-3:0] W_STATUS  = 4'd8;
    localparam logic [MB_AW-3:0] W_CONTROL = 4'd9;

    // top bit of each per-channel field; channel n sits at TOP-n
    localparam int F_PEND = 31;
    localparam int F_RXF  = 27;
    localparam int F_TXE  = 23;
    localparam int F_RING = 19;

    localparam int PAD_ST = MB_DW - 3*MB_CH - MB_NFLAG;
    localparam int PAD_CT = MB_DW - 4*MB_CH - MB_NFLAG;

    typedef logic [MB_CH-1:0]    chvec_t;
    typedef logic [MB_NFLAG-1:0] flag_t;

    typedef struct packed {
        chvec_t gie;
        chvec_t rie;
        chvec_t tie;
        flag_t  flg;
    } ctrl_t;

    // channel-indexed vector <-> reversed register field
    function automatic chvec_t flip(input chvec_t v);
        chvec_t r;
        for (int i = 0; i < MB_CH; i++) r[i] = v[MB_CH-1-i];
        return r;
    endfunction
endpackage

// File: rtl/mbox_lane.sv
// One direction of traffic: data slots, slot occupancy, doorbell pending bits.
module mbox_lane
    import mbox_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tx_we,
    input  logic [MB_IW-1:0]            tx_idx,
    input  logic [MB_DW-1:0]            tx_data,
    input  logic                        rx_re,
    input  logic [MB_IW-1:0]            rx_idx,
    input  chvec_t                      ring_mask,
    input  chvec_t                      ack_mask,
    output logic [MB_CH-1:0][MB_DW-1:0] words,
    output chvec_t                      full,
    output chvec_t                      pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
            full  <= '0;
            pend  <= '0;
        end else begin
            // R4: a read drains the slot
            if (rx_re) full[rx_idx] <= 1'b0;
            // R3: a write fills the slot
            if (tx_we) begin
                words[tx_idx] <= tx_data;
                full[tx_idx]  <= 1'b1;
            end
            // R5/R6: pending set by ring, cleared by write-one
            pend <= (pend & ~ack_mask) | ring_mask;
        end
    end
endmodule

// File: rtl/mbox_bank.sv
// Register bank of one side: decode, control word, read mux, interrupt.
module mbox_bank
    import mbox_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [MB_AW-1:0]            addr,
    input  logic [MB_DW-1:0]            wdata,
    output logic [MB_DW-1:0]            rdata,
    output logic                        irq,
    // outbound lane
    input  logic [MB_CH-1:0][MB_DW-1:0] out_words,
    input  chvec_t                      out_full,
    input  chvec_t                      out_pend,
    output logic                        tx_we,
    output logic [MB_IW-1:0]            tx_idx,
    output logic [MB_DW-1:0]            tx_data,
    output chvec_t                      ring_mask,
    // inbound lane
    input  logic [MB_CH-1:0][MB_DW-1:0] in_words,
    input  chvec_t                      in_full,
    input  chvec_t                      in_pend,
    output logic                        rx_re,
    output logic [MB_IW-1:0]            rx_idx,
    output chvec_t                      ack_mask,
    // general flags
    input  flag_t                       peer_flags,
    output flag_t                       own_flags
);
    ctrl_t ctl;

    logic             aligned;
    logic [MB_AW-3:0] word;
    logic             hit_tx, hit_rx, hit_st, hit_ct;

    assign aligned = (addr[1:0] == 2'b00);
    assign word    = addr[MB_AW-1:2];
    assign hit_tx  = aligned && (word[MB_AW-3:MB_IW] == '0);
    assign hit_rx  = aligned && (word[MB_AW-3:MB_IW] == 1);
    assign hit_st  = aligned && (word == W_STATUS);
    assign hit_ct  = aligned && (word == W_CONTROL);

    assign tx_we     = wr_en && hit_tx;
    assign tx_idx    = word[MB_IW-1:0];
    assign tx_data   = wdata;
    assign rx_re     = rd_en && hit_rx;
    assign rx_idx    = word[MB_IW-1:0];
    assign ring_mask = (wr_en && hit_ct) ? flip(wdata[F_RING -: MB_CH]) : '0;
    assign ack_mask  = (wr_en && hit_st) ? flip(wdata[F_PEND -: MB_CH]) : '0;
    assign own_flags = ctl.flg;

    // R7/R8: control word storage (doorbell request lives in the lane)
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr_en && hit_ct) begin
            ctl.gie <= flip(wdata[F_PEND -: MB_CH]);
            ctl.rie <= flip(wdata[F_RXF  -: MB_CH]);
            ctl.tie <= flip(wdata[F_TXE  -: MB_CH]);
            ctl.flg <= wdata[MB_NFLAG-1:0];
        end
    end

    logic [MB_DW-1:0] status_w, control_w;
    assign status_w  = {flip(in_pend), flip(in_full), flip(~out_full),
                        {PAD_ST{1'b0}}, peer_flags};
    assign control_w = {flip(ctl.gie), flip(ctl.rie), flip(ctl.tie),
                        flip(out_pend), {PAD_CT{1'b0}}, ctl.flg};

    always_comb begin
        rdata = '0;
        if (hit_tx)      rdata = out_words[word[MB_IW-1:0]];
        else if (hit_rx) rdata = in_words[word[MB_IW-1:0]];
        else if (hit_st) rdata = status_w;
        else if (hit_ct) rdata = control_w;
    end

    assign irq = |(in_pend & ctl.gie) | |(in_full & ctl.rie) | |(~out_full & ctl.tie);
endmodule

// File: rtl/mbox_dual.sv
module mbox_dual
    import mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             a_wr_en,
    input  logic             a_rd_en,
    input  logic [MB_AW-1:0] a_addr,
    input  logic [MB_DW-1:0] a_wdata,
    output logic [MB_DW-1:0] a_rdata,
    output logic             a_irq,
    input  logic             b_wr_en,
    input  logic             b_rd_en,
    input  logic [MB_AW-1:0] b_addr,
    input  logic [MB_DW-1:0] b_wdata,
    output logic [MB_DW-1:0] b_rdata,
    output logic             b_irq
);
    // lane ab carries A -> B, lane ba carries B -> A
    logic [MB_CH-1:0][MB_DW-1:0] ab_words, ba_words;
    chvec_t ab_full, ab_pend, ba_full, ba_pend;
    chvec_t ab_ring, ab_ack, ba_ring, ba_ack;
    logic ab_we, ab_re, ba_we, ba_re;
    logic [MB_IW-1:0] ab_widx, ab_ridx, ba_widx, ba_ridx;
    logic [MB_DW-1:0] ab_data, ba_data;
    flag_t a_flags, b_flags;

    mbox_lane u_lane_ab (
        .clk(clk), .rst(rst),
        .tx_we(ab_we), .tx_idx(ab_widx), .tx_data(ab_data),
        .rx_re(ab_re), .rx_idx(ab_ridx),
        .ring_mask(ab_ring), .ack_mask(ab_ack),
        .words(ab_words), .full(ab_full), .pend(ab_pend)
    );

    mbox_lane u_lane_ba (
        .clk(clk), .rst(rst),
        .tx_we(ba_we), .tx_idx(ba_widx), .tx_data(ba_data),
        .rx_re(ba_re), .rx_idx(ba_ridx),
        .ring_mask(ba_ring), .ack_mask(ba_ack),
        .words(ba_words), .full(ba_full), .pend(ba_pend)
    );

    mbox_bank u_bank_a (
        .clk(clk), .rst(rst),
        .wr_en(a_wr_en), .rd_en(a_rd_en), .addr(a_addr), .wdata(a_wdata),
        .rdata(a_rdata), .irq(a_irq),
        .out_words(ab_words), .out_full(ab_full), .out_pend(ab_pend),
        .tx_we(ab_we), .tx_idx(ab_widx), .tx_data(ab_data), .ring_mask(ab_ring),
        .in_words(ba_words), .in_full(ba_full), .in_pend(ba_pend),
        .rx_re(ba_re), .rx_idx(ba_ridx), .ack_mask(ba_ack),
        .peer_flags(b_flags), .own_flags(a_flags)
    );

    mbox_bank u_bank_b (
        .clk(clk), .rst(rst),
        .wr_en(b_wr_en), .rd_en(b_rd_en), .addr(b_addr), .wdata(b_wdata),
        .rdata(b_rdata), .irq(b_irq),
        .out_words(ba_words), .out_full(ba_full), .out_pend(ba_pend),
        .tx_we(ba_we), .tx_idx(ba_widx), .tx_data(ba_data), .ring_mask(ba_ring),
        .in_words(ab_words), .in_full(ab_full), .in_pend(ab_pend),
        .rx_re(ab_re), .rx_idx(ab_ridx), .ack_mask(ab_ack),
        .peer_flags(a_flags), .own_flags(b_flags)
    );
endmodule

// File: rtl/mbox_dual_chk.sv
// Protocol checker for the A -> B lane; side B to A is the mirror image.
module mbox_dual_chk
    import mbox_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             a_wr_en,
    input logic [MB_AW-1:0] a_addr,
    input logic [MB_CH-1:0] a_ring_bits,
    input logic             b_wr_en,
    input logic             b_rd_en,
    input logic [MB_AW-1:0] b_addr,
    input logic [MB_CH-1:0] b_clear_bits,
    input chvec_t           ab_full,
    input chvec_t           ab_pend
);
    for (genvar n = 0; n < MB_CH; n++) begin : g_ch
        localparam logic [MB_AW-1:0] TX_ADDR = MB_AW'(4*n);
        localparam logic [MB_AW-1:0] RX_ADDR = MB_AW'(16 + 4*n);
        localparam logic [MB_AW-1:0] ST_ADDR = MB_AW'(32);
        localparam logic [MB_AW-1:0] CT_ADDR = MB_AW'(36);

        // R3: a write to outbound slot n fills inbound slot n on the peer
        p_fill_r3: assert property (@(posedge clk) disable iff (rst)
            (a_wr_en && a_addr == TX_ADDR) |=> ab_full[n]);

        // R4: a read of a full slot, with no write to it, drains it
        p_drain_r4: assert property (@(posedge clk) disable iff (rst)
            (b_rd_en && b_addr == RX_ADDR && !(a_wr_en && a_addr == TX_ADDR))
            |=> !ab_full[n]);

        // R4: a slot only empties through a read by the receiver
        p_only_read_drains_r4: assert property (@(posedge clk) disable iff (rst)
            $fell(ab_full[n]) |-> $past(b_rd_en && b_addr == RX_ADDR));

        // R5: write-one clears a set pending bit
        p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
            (b_wr_en && b_addr == ST_ADDR && b_clear_bits[MB_CH-1-n] && ab_pend[n])
            |=> !ab_pend[n]);

        // R6: pending rises only after a doorbell ring from the peer
        p_ring_r6: assert property (@(posedge clk) disable iff (rst)
            $rose(ab_pend[n]) |-> $past(a_wr_en && a_addr == CT_ADDR && a_ring_bits[MB_CH-1-n]));
    end
endmodule

bind mbox_dual mbox_dual_chk u_chk (
    .clk(clk), .rst(rst),
    .a_wr_en(a_wr_en), .a_addr(a_addr), .a_ring_bits(a_wdata[19:16]),
    .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr),
    .b_clear_bits(b_wdata[31:28]),
    .ab_full(ab_full), .ab_pend(ab_pend)
);

// File: tb/mbox_dual_bench.sv
module mbox_dual_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_wr_en = 1'b0, a_rd_en = 1'b0, b_wr_en = 1'b0, b_rd_en = 1'b0;
    logic [5:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    mbox_dual u_mbox_dual (
        .clk(clk), .rst(rst),
        .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    typedef struct packed {
        logic        side;   // 0 = A, 1 = B
        logic        wr;     // 1 = write, 0 = read and compare
        logic [5:0]  addr;
        logic [31:0] data;   // write data or expected read data
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0,1'b0,6'h20,32'h00F00000,4'd2},   // R2 A status
        '{1'b0,1'b0,6'h24,32'h00000000,4'd2},   // R2 A control
        '{1'b1,1'b0,6'h20,32'h00F00000,4'd2},   // R2 B status
        '{1'b1,1'b0,6'h24,32'h00000000,4'd2},   // R2 B control
        '{1'b0,1'b1,6'h00,32'h11111111,4'd3},   // R3 A slot0
        '{1'b0,1'b1,6'h08,32'h22222222,4'd3},   // R3 A slot2
        '{1'b0,1'b0,6'h20,32'h00500000,4'd3},   // R3 TE0,TE2 clear
        '{1'b1,1'b0,6'h20,32'h0AF00000,4'd3},   // R3 RF0,RF2 set
        '{1'b0,1'b0,6'h08,32'h22222222,4'd1},   // R1 outbound readback
        '{1'b1,1'b0,6'h18,32'h22222222,4'd4},   // R4 drain slot2
        '{1'b1,1'b0,6'h20,32'h08F00000,4'd4},
        '{1'b0,1'b0,6'h20,32'h00700000,4'd4},
        '{1'b1,1'b0,6'h18,32'h22222222,4'd4},   // R4 read of empty slot
        '{1'b0,1'b0,6'h20,32'h00700000,4'd4},
        '{1'b1,1'b1,6'h10,32'h0000DEAD,4'd9},   // R9 write to inbound
        '{1'b1,1'b0,6'h10,32'h11111111,4'd9},
        '{1'b0,1'b0,6'h20,32'h00F00000,4'd4},
        '{1'b1,1'b1,6'h01,32'h00000077,4'd1},   // R1 misaligned write
        '{1'b0,1'b0,6'h20,32'h00F00000,4'd1},
        '{1'b0,1'b1,6'h24,32'h40040005,4'd6},   // R6 ring 1, GIE1, flags
        '{1'b0,1'b0,6'h24,32'h40040005,4'd7},   // R7 readback
        '{1'b1,1'b0,6'h20,32'h40F00005,4'd8},   // R8 flags, R6 pend1
        '{1'b1,1'b1,6'h24,32'h40000000,4'd7},
        '{1'b1,1'b0,6'h24,32'h40000000,4'd7},
        '{1'b1,1'b1,6'h20,32'h0FFFFFFF,4'd9},   // R9 no pending bits
        '{1'b1,1'b0,6'h20,32'h40F00005,4'd9},
        '{1'b1,1'b1,6'h20,32'h40000000,4'd5},   // R5 clear pend1
        '{1'b1,1'b0,6'h20,32'h00F00005,4'd5},
        '{1'b0,1'b0,6'h24,32'h40000005,4'd6},   // R6 request self-clears
        '{1'b1,1'b1,6'h0C,32'hCAFEF00D,4'd10},  // R10 B slot3
        '{1'b1,1'b0,6'h20,32'h00E00005,4'd10},
        '{1'b0,1'b0,6'h20,32'h01F00000,4'd10},
        '{1'b0,1'b0,6'h1C,32'hCAFEF00D,4'd10},
        '{1'b1,1'b0,6'h20,32'h00F00005,4'd10},
        '{1'b0,1'b1,6'h24,32'h40090005,4'd6},   // R6 ring 0 and 3
        '{1'b1,1'b0,6'h20,32'h90F00005,4'd6},
        '{1'b1,1'b1,6'h20,32'h80000000,4'd5},   // R5 clear only 0
        '{1'b1,1'b0,6'h20,32'h10F00005,4'd5},
        '{1'b0,1'b0,6'h24,32'h40010005,4'd5},
        '{1'b1,1'b1,6'h20,32'h10000000,4'd5},
        '{1'b0,1'b0,6'h24,32'h40000005,4'd6}
    };

    task automatic check(input logic ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic side, input logic [5:0] addr, input logic [31:0] data);
        @(negedge clk);
        if (side) begin b_wr_en = 1'b1; b_addr = addr; b_wdata = data; end
        else      begin a_wr_en = 1'b1; a_addr = addr; a_wdata = data; end
        @(negedge clk);
        a_wr_en = 1'b0; b_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic side, input logic [5:0] addr, input logic [31:0] exp, input int req);
        logic [31:0] got;
        @(negedge clk);
        if (side) begin b_rd_en = 1'b1; b_addr = addr; end
        else      begin a_rd_en = 1'b1; a_addr = addr; end
        #1;
        got = side ? b_rdata : a_rdata;
        check(got === exp, req, got, exp);
        @(negedge clk);
        a_rd_en = 1'b0; b_rd_en = 1'b0;
    endtask

    task automatic irq_chk(input logic exp_a, input logic exp_b, input int req);
        @(negedge clk); #1;
        check(a_irq === exp_a, req, {31'b0, a_irq}, {31'b0, exp_a});
        check(b_irq === exp_b, req, {31'b0, b_irq}, {31'b0, exp_b});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        irq_chk(1'b0, 1'b0, 2);  // R2 interrupts idle after reset

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_wr(VECS[i].side, VECS[i].addr, VECS[i].data);
            else            bus_rd(VECS[i].side, VECS[i].addr, VECS[i].data, int'(VECS[i].req));
        end

        // R7: interrupt merging
        irq_chk(1'b0, 1'b0, 7);
        bus_wr(1'b0, 6'h24, 32'h00800000);   // A: TIE0 only
        irq_chk(1'b1, 1'b0, 7);
        bus_wr(1'b0, 6'h00, 32'h5A5A5A5A);   // TE0 drops
        irq_chk(1'b0, 1'b0, 7);
        bus_wr(1'b1, 6'h24, 32'h08000000);   // B: RIE0 only
        irq_chk(1'b0, 1'b1, 7);
        bus_rd(1'b1, 6'h10, 32'h5A5A5A5A, 4);
        irq_chk(1'b1, 1'b0, 7);
        bus_rd(1'b1, 6'h20, 32'h00F00000, 8); // R8 A flags now 0
        bus_wr(1'b1, 6'h24, 32'h40000000);   // B: GIE1
        bus_wr(1'b0, 6'h24, 32'h00040000);   // A rings 1, TIE0 off
        irq_chk(1'b0, 1'b1, 7);
        bus_wr(1'b1, 6'h20, 32'h40000000);
        irq_chk(1'b0, 1'b0, 5);

        // R2: reset in the middle of traffic
        bus_wr(1'b0, 6'h04, 32'h0BADF00D);
        bus_wr(1'b0, 6'h24, 32'hFFF00007);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bus_rd(1'b0, 6'h20, 32'h00F00000, 2);
        bus_rd(1'b0, 6'h24, 32'h00000000, 2);
        bus_rd(1'b1, 6'h20, 32'h00F00000, 2);
        irq_chk(1'b0, 1'b0, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule